// File: doc/BRIEF.md
# Asynchronous static-memory access sequencer

This block turns one request from the on-chip side into the strobe waveforms of a single access to an asynchronous static memory: chip select, read strobe, write strobe and the byte-lane lines. A request (address, write data, direction and byte enables) is taken over a valid/ready handshake. An access counter then runs from zero, and each strobe is driven low inside a window set by its own setup and pulse counts. The access ends when the counter reaches the programmed total length, or the end of the longest strobe window if that comes later. A one-cycle done pulse follows, and on reads it carries the captured data.

The configuration arrives on static input ports that a register bank elsewhere holds stable while an access runs. It sets separate timing for reads and writes, a wait-input behaviour, the byte-lane signalling style, a narrow (8-bit) or wide (16-bit) data bus, and a count of bus-turnaround cycles after each read. The active-low wait input comes from the memory side. It can be ignored, it can freeze the whole access, or it can stretch the end of the controlling strobe.

Top module: `sram_seq_top`

## Requirements
- R1: During and straight after reset, every strobe and lane line is high, the data output enable and the done pulse are low, and the request ready is high.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready stays low for the whole access, and the first access cycle (counter 0) follows that edge.
- R3: Chip select is low while setup <= counter < setup + pulse, using the read pair of counts on reads and the write pair on writes. The read strobe uses the same rule with its read counts, on reads only.
- R4: An access lasts max(total cycle count, chip-select window end, controlling-strobe window end) cycles, with a minimum of one. The done output is high for the single cycle after the last access cycle.
- R5: Read data is sampled at the clock edge that ends the last cycle of the read strobe pulse and is presented with done. In narrow mode the upper byte of the result is zero.
- R6: For every cycle of a write access the data output enable is high and the write data is driven, with its upper byte forced to zero in narrow mode. Outside write accesses the enable is low.
- R7: With wait mode 0 or 3, the wait input has no effect on any output.
- R8: With wait mode 1, each access cycle in which the wait input is low repeats: the counter, strobes and lanes hold their values, and the access resumes from the same point once the wait input is high.
- R9: With wait mode 2, if the wait input is low in the last cycle of the controlling strobe pulse (write strobe on writes, read strobe on reads), that cycle repeats until the wait input is high. The wait input is ignored in every other cycle.
- R10: With byte-write style 0, writes use the single write strobe. Byte-select line i is low with chip select when lane i is enabled, on reads and on writes, and the per-lane write strobes stay high.
- R11: With byte-write style 1, per-lane write strobe i follows the write window when lane i is enabled. The single write strobe and all byte-select lines stay high, and reads use only chip select and the read strobe.
- R12: In narrow mode (wide = 0), lane 0 counts as enabled whatever the byte enables are, and the lane lines of the upper byte stay high.
- R13: After a read, the block spends the programmed float count of cycles in a turnaround state. In that state a read request is taken at once, and a write request waits until the state ends.
- R14: Done is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane enables |
| cfg_wr_we_setup | input | SETUP_W | Write strobe setup count |
| cfg_wr_we_pulse | input | PULSE_W | Write strobe pulse count |
| cfg_wr_cs_setup | input | SETUP_W | Chip-select setup count on writes |
| cfg_wr_cs_pulse | input | PULSE_W | Chip-select pulse count on writes |
| cfg_wr_cycle | input | CYCLE_W | Total write access length |
| cfg_rd_re_setup | input | SETUP_W | Read strobe setup count |
| cfg_rd_re_pulse | input | PULSE_W | Read strobe pulse count |
| cfg_rd_cs_setup | input | SETUP_W | Chip-select setup count on reads |
| cfg_rd_cs_pulse | input | PULSE_W | Chip-select pulse count on reads |
| cfg_rd_cycle | input | CYCLE_W | Total read access length |
| cfg_wait_mode | input | 2 | 0/3 ignore, 1 freeze, 2 ready-extend |
| cfg_byte_write | input | 1 | Lane signalling style (0 lane select, 1 per-lane write strobes) |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_float | input | FLOAT_W | Turnaround cycles after a read |
| mem_addr | output | ADDR_W | Address to memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Single write strobe, active low |
| mem_bwe_n | output | DATA_W/8 | Per-lane write strobes, active low |
| mem_bs_n | output | DATA_W/8 | Byte-select lines, active low |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | DATA_W | Data from memory |
| mem_wait_n | input | 1 | Wait from memory, active low |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | DATA_W | Read result |

## Verification
The bench drives the memory data bus with a value that changes every cycle, so sampling read data one cycle early or late shows up as a wrong result. It holds the wait input low across whole accesses in the ignore modes, where a design that still honoured it would stretch the access. In freeze mode it pulses the wait input in the middle of an access, where a design that let any counter run would end early. In ready mode it holds the wait input low through the end of the strobe pulse, where a design that did not extend the pulse would finish one or more cycles too soon. Other cases cover a total length shorter than the strobe windows, an all-zero timing setup, lanes in both signalling styles and both bus widths, and a write that arrives during the turnaround after a read, which a design that ignored the turnaround would take too early.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  // Wait-input behaviour; code 3 behaves like WAIT_IGNORE.
  typedef enum logic [1:0] {
    WAIT_IGNORE = 2'd0,
    WAIT_FREEZE = 2'd1,
    WAIT_READY  = 2'd2,
    WAIT_SPARE  = 2'd3
  } wait_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sram_seq_window.sv
// Decodes one strobe window [setup, setup+pulse) against the access counter.
module sram_seq_window #(
  parameter int CNT_W   = 9,
  parameter int SETUP_W = 6,
  parameter int PULSE_W = 7
) (
  input  logic [CNT_W-1:0]   cnt,
  input  logic [SETUP_W-1:0] setup,
  input  logic [PULSE_W-1:0] pulse,
  output logic               active,
  output logic [CNT_W-1:0]   end_cnt
);
  logic [CNT_W-1:0] start_cnt;

  assign start_cnt = CNT_W'(setup);
  assign end_cnt   = start_cnt + CNT_W'(pulse);
  assign active    = (cnt >= start_cnt) && (cnt < end_cnt);

endmodule

// File: rtl/sram_seq_counter.sv
// Access-cycle counter with clear and advance enables.
module sram_seq_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_seq_lanes.sv
// Byte-lane strobes and write data path for both signalling styles and widths.
module sram_seq_lanes #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              cs_on,
  input  logic              we_on,
  input  logic              byte_write,
  input  logic              wide,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic              we_n,
  output logic [LANES-1:0]  bwe_n,
  output logic [LANES-1:0]  bs_n,
  output logic [DATA_W-1:0] dq_out
);
  logic [LANES-1:0] lane_en;

  assign we_n = !(we_on && !byte_write);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_low
      assign lane_en[i]       = wide ? be[i] : 1'b1;
      assign dq_out[7:0]      = wdata[7:0];
    end else begin : g_high
      assign lane_en[i]       = wide && be[i];
      assign dq_out[i*8 +: 8] = wide ? wdata[i*8 +: 8] : 8'h00;
    end
    assign bs_n[i]  = !(cs_on && !byte_write && lane_en[i]);
    assign bwe_n[i] = !(we_on && byte_write && lane_en[i]);
  end

endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int SETUP_W = 6,
  parameter int PULSE_W = 7,
  parameter int CYCLE_W = 9,
  parameter int FLOAT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  input  logic [SETUP_W-1:0]    cfg_wr_we_setup,
  input  logic [PULSE_W-1:0]    cfg_wr_we_pulse,
  input  logic [SETUP_W-1:0]    cfg_wr_cs_setup,
  input  logic [PULSE_W-1:0]    cfg_wr_cs_pulse,
  input  logic [CYCLE_W-1:0]    cfg_wr_cycle,
  input  logic [SETUP_W-1:0]    cfg_rd_re_setup,
  input  logic [PULSE_W-1:0]    cfg_rd_re_pulse,
  input  logic [SETUP_W-1:0]    cfg_rd_cs_setup,
  input  logic [PULSE_W-1:0]    cfg_rd_cs_pulse,
  input  logic [CYCLE_W-1:0]    cfg_rd_cycle,
  input  logic [1:0]            cfg_wait_mode,
  input  logic                  cfg_byte_write,
  input  logic                  cfg_wide,
  input  logic [FLOAT_W-1:0]    cfg_float,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_cs_n,
  output logic                  mem_re_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_bwe_n,
  output logic [DATA_W/8-1:0]   mem_bs_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in,
  input  logic                  mem_wait_n,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     rsp_rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = CYCLE_W;

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [FLOAT_W-1:0] fl_q, fl_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic [LANES-1:0]  be_q;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic              accept, in_acc, stall, last_cyc, cap;
  logic [SETUP_W-1:0] cs_setup;
  logic [PULSE_W-1:0] cs_pulse;
  logic              cs_win, we_win, re_win;
  logic [CNT_W-1:0]  cs_end, we_end, re_end;
  logic              cs_on, we_on, re_on;
  logic              ctrl_on, ctrl_last;
  logic [CNT_W-1:0]  ctrl_end, acc_len, cyc_len;
  wait_mode_e        wmode;

  assign wmode  = wait_mode_e'(cfg_wait_mode);
  assign in_acc = (state_q == ST_ACCESS);

  // Request handshake: reads may start during turnaround, writes may not.
  assign req_ready = (state_q == ST_IDLE) || ((state_q == ST_FLOAT) && !req_write);
  assign accept    = req_valid && req_ready;

  // Direction-dependent chip-select timing.
  assign cs_setup = wr_q ? cfg_wr_cs_setup : cfg_rd_cs_setup;
  assign cs_pulse = wr_q ? cfg_wr_cs_pulse : cfg_rd_cs_pulse;
  assign cyc_len  = wr_q ? cfg_wr_cycle    : cfg_rd_cycle;

  sram_seq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .adv   (in_acc && !stall && !last_cyc),
    .cnt_q (cnt_q)
  );

  sram_seq_window #(.CNT_W(CNT_W), .SETUP_W(SETUP_W), .PULSE_W(PULSE_W)) u_win_cs (
    .cnt (cnt_q), .setup (cs_setup), .pulse (cs_pulse),
    .active (cs_win), .end_cnt (cs_end)
  );

  sram_seq_window #(.CNT_W(CNT_W), .SETUP_W(SETUP_W), .PULSE_W(PULSE_W)) u_win_we (
    .cnt (cnt_q), .setup (cfg_wr_we_setup), .pulse (cfg_wr_we_pulse),
    .active (we_win), .end_cnt (we_end)
  );

  sram_seq_window #(.CNT_W(CNT_W), .SETUP_W(SETUP_W), .PULSE_W(PULSE_W)) u_win_re (
    .cnt (cnt_q), .setup (cfg_rd_re_setup), .pulse (cfg_rd_re_pulse),
    .active (re_win), .end_cnt (re_end)
  );

  assign cs_on = in_acc && cs_win;
  assign we_on = in_acc && wr_q && we_win;
  assign re_on = in_acc && !wr_q && re_win;

  assign ctrl_on   = wr_q ? we_on : re_on;
  assign ctrl_end  = wr_q ? we_end : re_end;
  assign ctrl_last = ctrl_on && (cnt_q == ctrl_end - 1'b1);

  // Access length: the longest of total count and the two strobe windows.
  always_comb begin
    acc_len = cyc_len;
    if (cs_end > acc_len) acc_len = cs_end;
    if (ctrl_end > acc_len) acc_len = ctrl_end;
    if (acc_len == '0) acc_len = CNT_W'(1);
  end
  assign last_cyc = (cnt_q == acc_len - 1'b1);

  // Wait handling.
  always_comb begin
    stall = 1'b0;
    if (in_acc && !mem_wait_n) begin
      unique case (wmode)
        WAIT_FREEZE: stall = 1'b1;
        WAIT_READY:  stall = ctrl_last;
        default:     stall = 1'b0;
      endcase
    end
  end

  // Read capture at the last read-strobe cycle.
  assign cap     = re_on && (cnt_q == re_end - 1'b1) && !stall;
  assign rdata_d = cfg_wide ? mem_dq_in : DATA_W'(mem_dq_in[7:0]);

  // Sequencer next state.
  always_comb begin
    state_d = state_q;
    fl_d    = fl_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (!stall && last_cyc) begin
          done_d = 1'b1;
          if (!wr_q && (cfg_float != '0)) begin
            state_d = ST_FLOAT;
            fl_d    = cfg_float;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_FLOAT: begin
        if (accept) begin
          state_d = ST_ACCESS;
        end else if (fl_q <= FLOAT_W'(1)) begin
          state_d = ST_IDLE;
        end else begin
          fl_d = fl_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fl_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fl_q    <= fl_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      be_q   <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      addr_q <= req_addr;
      wd_q   <= req_wdata;
      be_q   <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap) begin
      rdata_q <= rdata_d;
    end
  end

  sram_seq_lanes #(.DATA_W(DATA_W)) u_lanes (
    .cs_on      (cs_on),
    .we_on      (we_on),
    .byte_write (cfg_byte_write),
    .wide       (cfg_wide),
    .be         (be_q),
    .wdata      (wd_q),
    .we_n       (mem_we_n),
    .bwe_n      (mem_bwe_n),
    .bs_n       (mem_bs_n),
    .dq_out     (mem_dq_out)
  );

  assign mem_addr  = addr_q;
  assign mem_cs_n  = !cs_on;
  assign mem_re_n  = !re_on;
  assign mem_dq_oe = in_acc && wr_q;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk
  import sram_seq_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       cfg_wait_mode,
  input logic             cfg_byte_write,
  input logic             cfg_wide,
  input logic             mem_wait_n,
  input logic             mem_cs_n,
  input logic             mem_re_n,
  input logic             mem_we_n,
  input logic [LANES-1:0] mem_bs_n,
  input logic [LANES-1:0] mem_bwe_n,
  input logic             mem_dq_oe,
  input logic             req_ready,
  input logic             rsp_done
);

  assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'(ST_ACCESS) && wait_mode_e'(cfg_wait_mode) == WAIT_FREEZE && !mem_wait_n)
      |=> ($stable(cnt) && state == 2'(ST_ACCESS)));

  assert_no_read_while_driving_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_re_n);

  assert_byte_write_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_byte_write |-> (mem_we_n && (&mem_bs_n)));

  assert_narrow_upper_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wide |-> ((&mem_bs_n[LANES-1:1]) && (&mem_bwe_n[LANES-1:1])));

endmodule

bind sram_seq_top sram_seq_chk #(.CNT_W(CNT_W), .LANES(LANES)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .state          (state_q),
  .cnt            (cnt_q),
  .cfg_wait_mode  (cfg_wait_mode),
  .cfg_byte_write (cfg_byte_write),
  .cfg_wide       (cfg_wide),
  .mem_wait_n     (mem_wait_n),
  .mem_cs_n       (mem_cs_n),
  .mem_re_n       (mem_re_n),
  .mem_we_n       (mem_we_n),
  .mem_bs_n       (mem_bs_n),
  .mem_bwe_n      (mem_bwe_n),
  .mem_dq_oe      (mem_dq_oe),
  .req_ready      (req_ready),
  .rsp_done       (rsp_done)
);

// File: tb/sram_seq_top_tb_top.sv
`timescale 1ns/1ps
module sram_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic [5:0]  cfg_wr_we_setup, cfg_wr_cs_setup, cfg_rd_re_setup, cfg_rd_cs_setup;
  logic [6:0]  cfg_wr_we_pulse, cfg_wr_cs_pulse, cfg_rd_re_pulse, cfg_rd_cs_pulse;
  logic [8:0]  cfg_wr_cycle, cfg_rd_cycle;
  logic [1:0]  cfg_wait_mode;
  logic        cfg_byte_write, cfg_wide;
  logic [3:0]  cfg_float;
  logic [19:0] mem_addr;
  logic        mem_cs_n, mem_re_n, mem_we_n, mem_dq_oe, mem_wait_n, rsp_done;
  logic [1:0]  mem_bwe_n, mem_bs_n;
  logic [15:0] mem_dq_out, mem_dq_in, rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sram_seq_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .cfg_wr_we_setup(cfg_wr_we_setup), .cfg_wr_we_pulse(cfg_wr_we_pulse),
    .cfg_wr_cs_setup(cfg_wr_cs_setup), .cfg_wr_cs_pulse(cfg_wr_cs_pulse),
    .cfg_wr_cycle(cfg_wr_cycle),
    .cfg_rd_re_setup(cfg_rd_re_setup), .cfg_rd_re_pulse(cfg_rd_re_pulse),
    .cfg_rd_cs_setup(cfg_rd_cs_setup), .cfg_rd_cs_pulse(cfg_rd_cs_pulse),
    .cfg_rd_cycle(cfg_rd_cycle),
    .cfg_wait_mode(cfg_wait_mode), .cfg_byte_write(cfg_byte_write),
    .cfg_wide(cfg_wide), .cfg_float(cfg_float),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n),
    .mem_we_n(mem_we_n), .mem_bwe_n(mem_bwe_n), .mem_bs_n(mem_bs_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_wait_n(mem_wait_n), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory side data changes every cycle so the capture cycle matters.
  always @(negedge clk) begin
    if (!rst_n) mem_dq_in <= 16'h5a00;
    else        mem_dq_in <= mem_dq_in + 16'h0b3d;
  end

  // ---------------- behavioural reference model ----------------
  int m_state, m_cnt, m_fl, m_wr, m_be, m_wd, m_done, m_rdata;

  function automatic bit inwin(int c, int s, int p);
    return (c >= s) && (c < s + p);
  endfunction

  function automatic int cs_s(); return m_wr ? int'(cfg_wr_cs_setup) : int'(cfg_rd_cs_setup); endfunction
  function automatic int cs_p(); return m_wr ? int'(cfg_wr_cs_pulse) : int'(cfg_rd_cs_pulse); endfunction
  function automatic int ct_s(); return m_wr ? int'(cfg_wr_we_setup) : int'(cfg_rd_re_setup); endfunction
  function automatic int ct_p(); return m_wr ? int'(cfg_wr_we_pulse) : int'(cfg_rd_re_pulse); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_fl = 0; m_wr = 0; m_be = 0; m_wd = 0;
      m_done = 0; m_rdata = 0;
    end else begin
      bit rdy, acc, stl;
      int len;
      rdy = (m_state == 0) || (m_state == 2 && !req_write);
      acc = req_valid && rdy;
      m_done = 0;
      if (m_state == 1) begin
        len = m_wr ? int'(cfg_wr_cycle) : int'(cfg_rd_cycle);
        if (cs_s() + cs_p() > len) len = cs_s() + cs_p();
        if (ct_s() + ct_p() > len) len = ct_s() + ct_p();
        if (len == 0) len = 1;
        stl = 0;
        if (!mem_wait_n && cfg_wait_mode == 2'd1) stl = 1;
        if (!mem_wait_n && cfg_wait_mode == 2'd2 && ct_p() > 0 &&
            m_cnt == ct_s() + ct_p() - 1) stl = 1;
        if (!stl) begin
          if (!m_wr && ct_p() > 0 && m_cnt == ct_s() + ct_p() - 1)
            m_rdata = cfg_wide ? int'(mem_dq_in) : int'(mem_dq_in[7:0]);
          if (m_cnt == len - 1) begin
            m_done = 1;
            if (!m_wr && cfg_float != 0) begin m_state = 2; m_fl = int'(cfg_float); end
            else m_state = 0;
          end else begin
            m_cnt++;
          end
        end
      end else if (acc) begin
        m_state = 1; m_cnt = 0;
        m_wr = req_write; m_be = req_be; m_wd = req_wdata;
      end else if (m_state == 2) begin
        if (m_fl <= 1) m_state = 0;
        else m_fl--;
      end
    end
  end

  // Per-cycle comparison, sampled mid-cycle.
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit in_acc, cs_on, we_on, re_on;
      int ebs, ebwe, ewe, edq;
      string mt, st;
      mt = (cfg_wait_mode == 2'd1) ? " R8" : (cfg_wait_mode == 2'd2) ? " R9" : " R7";
      st = cfg_byte_write ? " R11" : " R10";
      if (!cfg_wide) st = {st, " R12"};
      in_acc = (m_state == 1);
      cs_on = in_acc && inwin(m_cnt, cs_s(), cs_p());
      we_on = in_acc && m_wr && inwin(m_cnt, ct_s(), ct_p());
      re_on = in_acc && !m_wr && inwin(m_cnt, ct_s(), ct_p());
      ebs = 3; ebwe = 3;
      for (int i = 0; i < 2; i++) begin
        bit en;
        en = cfg_wide ? m_be[i] : (i == 0);
        if (cs_on && !cfg_byte_write && en) ebs &= ~(1 << i);
        if (we_on && cfg_byte_write && en) ebwe &= ~(1 << i);
      end
      ewe = !(we_on && !cfg_byte_write);
      edq = cfg_wide ? m_wd : (m_wd & 8'hff);
      chk((m_state == 2) ? "R13 ready" : "R2 ready", int'(req_ready),
          int'((m_state == 0) || (m_state == 2 && !req_write)));
      chk({"R3 cs_n", mt}, int'(mem_cs_n), int'(!cs_on));
      chk({"R3 re_n", mt, st}, int'(mem_re_n), int'(!re_on));
      chk({"we_n", mt, st}, int'(mem_we_n), ewe);
      chk({"bs_n", mt, st}, int'(mem_bs_n), ebs);
      chk({"bwe_n", mt, st}, int'(mem_bwe_n), ebwe);
      chk({"R6 oe", mt}, int'(mem_dq_oe), int'(in_acc && m_wr));
      if (mem_dq_oe) chk({"R6 dq_out", st}, int'(mem_dq_out), edq);
      chk({"R4 R14 done", mt}, int'(rsp_done), m_done);
      if (rsp_done && m_rdata >= 0) chk({"R5 rdata", mt, st}, int'(rsp_rdata), m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_req(input bit wr, input logic [19:0] a, input logic [15:0] d,
                         input logic [1:0] be, input int wfrom, input int wlen);
    bit seen;
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    seen = 1'b0;
    while (!seen) begin
      #3;
      seen = req_ready;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R2 address held", int'(mem_addr), int'(a));
    k = 0;
    forever begin
      mem_wait_n = !((k >= wfrom) && (k < wfrom + wlen));
      #2;
      if (rsp_done) break;
      @(negedge clk);
      k++;
      if (k > 3000) break;
    end
    mem_wait_n = 1'b1;
  endtask

  task automatic base_cfg();
    cfg_wr_we_setup = 6'd2; cfg_wr_we_pulse = 7'd3;
    cfg_wr_cs_setup = 6'd1; cfg_wr_cs_pulse = 7'd5; cfg_wr_cycle = 9'd8;
    cfg_rd_re_setup = 6'd1; cfg_rd_re_pulse = 7'd4;
    cfg_rd_cs_setup = 6'd0; cfg_rd_cs_pulse = 7'd6; cfg_rd_cycle = 9'd7;
    cfg_wait_mode = 2'd0; cfg_byte_write = 1'b0; cfg_wide = 1'b1; cfg_float = 4'd2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_be = '0; mem_wait_n = 1'b1;
    base_cfg();
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    chk("R1 cs_n", int'(mem_cs_n), 1);
    chk("R1 re_n", int'(mem_re_n), 1);
    chk("R1 we_n", int'(mem_we_n), 1);
    chk("R1 bs_n", int'(mem_bs_n), 3);
    chk("R1 bwe_n", int'(mem_bwe_n), 3);
    chk("R1 oe", int'(mem_dq_oe), 0);
    chk("R1 done", int'(rsp_done), 0);
    chk("R1 ready", int'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // Basic write and reads (R3, R4, R5, R6, R10)
    run_req(1'b1, 20'h00100, 16'hbeef, 2'b11, 99, 0);
    run_req(1'b0, 20'h00104, 16'h0000, 2'b11, 99, 0);
    // R13: read accepted during turnaround, then write held off
    run_req(1'b0, 20'h00108, 16'h0000, 2'b01, 99, 0);
    run_req(1'b1, 20'h0010c, 16'h1234, 2'b10, 99, 0);
    run_req(1'b1, 20'h00110, 16'h5678, 2'b01, 99, 0);
    run_req(1'b0, 20'h00114, 16'h0000, 2'b10, 99, 0);

    // R7: wait ignored in modes 0 and 3
    run_req(1'b1, 20'h00200, 16'hcafe, 2'b11, 0, 40);
    cfg_wait_mode = 2'd3;
    run_req(1'b0, 20'h00204, 16'h0000, 2'b11, 0, 40);

    // R8: freeze mid-access
    cfg_wait_mode = 2'd1;
    run_req(1'b0, 20'h00300, 16'h0000, 2'b11, 2, 3);
    run_req(1'b1, 20'h00304, 16'ha5a5, 2'b11, 4, 2);

    // R9: ready-extend
    cfg_wait_mode = 2'd2;
    run_req(1'b0, 20'h00400, 16'h0000, 2'b11, 0, 9);
    run_req(1'b1, 20'h00404, 16'h0f0f, 2'b11, 0, 7);
    run_req(1'b1, 20'h00408, 16'hf0f0, 2'b11, 99, 0);
    cfg_wait_mode = 2'd0;

    // R11: per-lane write strobes
    cfg_byte_write = 1'b1;
    run_req(1'b1, 20'h00500, 16'h1111, 2'b10, 99, 0);
    run_req(1'b1, 20'h00504, 16'h2222, 2'b11, 99, 0);
    run_req(1'b0, 20'h00508, 16'h0000, 2'b01, 99, 0);

    // R12: narrow bus in both styles
    cfg_wide = 1'b0;
    run_req(1'b1, 20'h00600, 16'habcd, 2'b10, 99, 0);
    run_req(1'b0, 20'h00601, 16'h0000, 2'b00, 99, 0);
    cfg_byte_write = 1'b0;
    run_req(1'b1, 20'h00602, 16'h7788, 2'b00, 99, 0);
    run_req(1'b0, 20'h00603, 16'h0000, 2'b11, 99, 0);
    cfg_wide = 1'b1;

    // R4: total length shorter than the strobe windows
    cfg_wr_cycle = 9'd1; cfg_rd_cycle = 9'd2;
    run_req(1'b1, 20'h00700, 16'h4444, 2'b11, 99, 0);
    run_req(1'b0, 20'h00704, 16'h0000, 2'b11, 99, 0);

    // R4: all timing zero, one-cycle access with no strobes
    cfg_wr_we_setup = '0; cfg_wr_we_pulse = '0; cfg_wr_cs_setup = '0;
    cfg_wr_cs_pulse = '0; cfg_wr_cycle = '0;
    cfg_rd_re_setup = '0; cfg_rd_re_pulse = '0; cfg_rd_cs_setup = '0;
    cfg_rd_cs_pulse = '0; cfg_rd_cycle = '0;
    run_req(1'b1, 20'h00800, 16'h9999, 2'b11, 99, 0);
    run_req(1'b0, 20'h00804, 16'h0000, 2'b11, 99, 0);

    // R13: no turnaround when float count is zero
    base_cfg();
    cfg_float = 4'd0;
    run_req(1'b0, 20'h00900, 16'h0000, 2'b11, 99, 0);
    run_req(1'b1, 20'h00904, 16'h3333, 2'b11, 99, 0);
    cfg_float = 4'd5;
    run_req(1'b0, 20'h00908, 16'h0000, 2'b11, 99, 0);
    run_req(1'b1, 20'h0090c, 16'h6666, 2'b11, 99, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule